// File: doc/BRIEF.md
# Bidirectional Data Buffer Direction Sequencer

This block steers one bidirectional data buffer that joins a processor data bus to a peripheral data bus. The buffer's output enable is tied active for good. Only its direction is switched, so the buffer always drives one side or the other. At rest the buffer carries processor data toward the peripheral. The block watches the synchronous processor strobes (select, read, write). During a read from the selected peripheral it turns the buffer around so that it drives the processor bus. A guard interval of a set number of clock cycles is placed before each change of direction, so that two drivers never fight on either side.

The block brings out two qualifying strobes: a write-go strobe for the processor's data drivers and a read-window strobe for the peripheral's output drivers. It also brings out a busy flag that an external wait-state generator can use to stretch back-to-back cycles. A behavioural model of the buffered data path is included. It shows the value present on each side and raises a clash flag if two drivers meet on the same side.

Top module: `bus_dir_ctrl`

## Requirements
- R1: The buffer output enable `buf_oe_o` is 1 in every cycle, including during reset.
- R2: After a synchronous active-high reset, `dir_o` is 0 (toward the peripheral), `busy_o` is 0, `rd_win_o` is 0, and no clash flag is raised.
- R3: A read request is select and read both high. It is first sampled by a clock edge while the block is idle. `dir_o` stays 0 for TURN_CYC further edges and becomes 1 at edge TURN_CYC+1 after that first edge. At that same edge `rd_win_o` becomes 1.
- R4: Write cycles and idle cycles never change `dir_o` from 0. A read strobe with select low counts as idle.
- R5: Once the read request is sampled low during the read window, `rd_win_o` drops at that edge. `dir_o` stays 1 for TURN_CYC more edges and returns to 0 at the following edge.
- R6: If the read request drops before the turnaround toward the processor completes, `dir_o` never becomes 1. The block goes through the return turnaround and is idle TURN_CYC+1 edges after the drop is first sampled.
- R7: `busy_o` is 1 in every cycle in which the block is not idle.
- R8: `wr_go_o` is high only while a write request (select and write high, read low) is present and the block is idle. A write raised during the return turnaround is held off until idle is reached. When read and write are both high, the read wins.
- R9: `rd_win_o` is never high unless `dir_o` is 1.
- R10: With `dir_o` = 0, `periph_bus_o` carries `proc_wdata_i` while the processor drives. With `dir_o` = 1, `proc_bus_o` carries `periph_rdata_i` while the peripheral drives. An undriven side reads 0.
- R11: With the processor gated by `wr_go_o` and the peripheral gated by `rd_win_o`, `proc_clash_o` and `periph_clash_o` stay 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_i | input | 1 | Peripheral select strobe |
| rd_i | input | 1 | Processor read strobe |
| wr_i | input | 1 | Processor write strobe |
| proc_wdata_i | input | DW | Data the processor places on its side |
| periph_rdata_i | input | DW | Data the peripheral places on its side |
| buf_oe_o | output | 1 | Buffer output enable, always 1 |
| dir_o | output | 1 | Buffer direction, 1 = drive processor side |
| busy_o | output | 1 | Block is not idle |
| wr_go_o | output | 1 | Processor may drive write data |
| rd_win_o | output | 1 | Peripheral may drive read data |
| proc_bus_o | output | DW | Resolved processor-side value |
| periph_bus_o | output | DW | Resolved peripheral-side value |
| proc_clash_o | output | 1 | Two drivers on the processor side |
| periph_clash_o | output | 1 | Two drivers on the peripheral side |

## Verification
The bench runs with a two-cycle turnaround. With that setting, a counter that is off by one shifts the edge on which the direction flips in either direction, and the bench catches it. It aborts a read in the middle of the turnaround toward the processor: a design that ignored the abort would turn the buffer toward the processor with nobody reading. It raises a write during the return turnaround: a design that let the write through would have the processor and the buffer fighting on the processor side. It also presents read and write together and a read with select low. A wrong priority or a missing select qualifier shows up as a stray write-go strobe or a stray direction change.

// File: rtl/bdc_pkg.sv
package bdc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE_OUT = 2'd0,
    ST_TURN_IN  = 2'd1,
    ST_READ_IN  = 2'd2,
    ST_TURN_OUT = 2'd3
  } bdc_state_e;

  function automatic logic read_req(input logic cs, input logic rd);
    return cs & rd;
  endfunction

  function automatic logic write_req(input logic cs, input logic rd, input logic wr);
    return cs & wr & ~rd;
  endfunction

  function automatic int unsigned drivers_on_side(input logic a, input logic b);
    return int'(a) + int'(b);
  endfunction

endpackage

// File: rtl/bdc_turn_timer.sv
module bdc_turn_timer #(
  parameter int unsigned TURN_CYC = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic dec,
  output logic done
);
  localparam int unsigned CW = (TURN_CYC > 1) ? $clog2(TURN_CYC) : 1;
  localparam logic [CW-1:0] LOAD_VAL = CW'(TURN_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                    cnt_q <= '0;
    else if (load)              cnt_q <= LOAD_VAL;
    else if (dec && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

  a_r3_timer_load: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == LOAD_VAL));
endmodule

// File: rtl/bdc_fsm.sv
module bdc_fsm
  import bdc_pkg::*;
#(
  parameter int unsigned TURN_CYC = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic rd_req,
  input  logic wr_req,
  output logic dir,
  output logic busy,
  output logic wr_go,
  output logic rd_win
);
  bdc_state_e st_q, st_d;
  logic dir_q, dir_d;
  logic t_load, t_dec, t_done;

  bdc_turn_timer #(.TURN_CYC(TURN_CYC)) u_timer (
    .clk(clk), .rst(rst), .load(t_load), .dec(t_dec), .done(t_done)
  );

  // named internal events for the assertions
  logic ev_enter_read, ev_abort, ev_back_idle;

  always_comb begin
    st_d   = st_q;
    dir_d  = dir_q;
    t_load = 1'b0;
    t_dec  = 1'b0;
    ev_enter_read = 1'b0;
    ev_abort      = 1'b0;
    ev_back_idle  = 1'b0;
    case (st_q)
      ST_IDLE_OUT: if (rd_req) begin
        st_d = ST_TURN_IN; t_load = 1'b1;
      end
      ST_TURN_IN: begin
        if (!rd_req) begin
          st_d = ST_TURN_OUT; t_load = 1'b1; ev_abort = 1'b1;
        end else if (t_done) begin
          st_d = ST_READ_IN; dir_d = 1'b1; ev_enter_read = 1'b1;
        end else t_dec = 1'b1;
      end
      ST_READ_IN: if (!rd_req) begin
        st_d = ST_TURN_OUT; t_load = 1'b1;
      end
      ST_TURN_OUT: begin
        if (t_done) begin
          st_d = ST_IDLE_OUT; dir_d = 1'b0; ev_back_idle = 1'b1;
        end else t_dec = 1'b1;
      end
      default: st_d = ST_IDLE_OUT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE_OUT;
      dir_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      dir_q <= dir_d;
    end
  end

  assign dir    = dir_q;
  assign busy   = (st_q != ST_IDLE_OUT);
  assign wr_go  = wr_req && (st_q == ST_IDLE_OUT);
  assign rd_win = (st_q == ST_READ_IN);

  a_r3_rise_only_into_read: assert property (@(posedge clk) disable iff (rst)
    $rose(dir_q) |-> (st_q == ST_READ_IN));
  a_r6_no_flip_in_turn_in: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_TURN_IN) |-> !dir_q);
  a_r6_abort_goes_out: assert property (@(posedge clk) disable iff (rst)
    ev_abort |=> (st_q == ST_TURN_OUT && !dir_q));
  a_r5_fall_only_to_idle: assert property (@(posedge clk) disable iff (rst)
    $fell(dir_q) |-> (st_q == ST_IDLE_OUT));
  a_r8_write_when_idle: assert property (@(posedge clk) disable iff (rst)
    wr_go |-> (!dir_q && !rd_req));
  a_r9_window_has_dir: assert property (@(posedge clk) disable iff (rst)
    rd_win |-> dir_q);
  a_r4_idle_dir_low: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE_OUT) |-> !dir_q);
endmodule

// File: rtl/bdc_datapath.sv
module bdc_datapath
  import bdc_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dir,
  input  logic          proc_en,
  input  logic          periph_en,
  input  logic [DW-1:0] proc_wdata,
  input  logic [DW-1:0] periph_rdata,
  output logic [DW-1:0] proc_bus,
  output logic [DW-1:0] periph_bus,
  output logic          proc_clash,
  output logic          periph_clash
);
  logic [DW-1:0] proc_src, periph_src;

  assign proc_src   = proc_en   ? proc_wdata   : '0;
  assign periph_src = periph_en ? periph_rdata : '0;

  // buffer always enabled: it drives whichever side dir selects
  assign proc_bus   = dir ? periph_src : proc_src;
  assign periph_bus = dir ? periph_src : proc_src;

  assign proc_clash   = drivers_on_side(proc_en, dir) > 1;
  assign periph_clash = drivers_on_side(periph_en, !dir) > 1;

  a_r11_no_clash: assert property (@(posedge clk) disable iff (rst)
    !proc_clash && !periph_clash);
endmodule

// File: rtl/bus_dir_ctrl.sv
module bus_dir_ctrl
  import bdc_pkg::*;
#(
  parameter int unsigned DW       = 8,
  parameter int unsigned TURN_CYC = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [DW-1:0] proc_wdata_i,
  input  logic [DW-1:0] periph_rdata_i,
  output logic          buf_oe_o,
  output logic          dir_o,
  output logic          busy_o,
  output logic          wr_go_o,
  output logic          rd_win_o,
  output logic [DW-1:0] proc_bus_o,
  output logic [DW-1:0] periph_bus_o,
  output logic          proc_clash_o,
  output logic          periph_clash_o
);
  logic rd_req, wr_req;
  logic dir_w, wr_go_w, rd_win_w;

  assign rd_req = read_req(cs_i, rd_i);
  assign wr_req = write_req(cs_i, rd_i, wr_i);

  bdc_fsm #(.TURN_CYC(TURN_CYC)) u_fsm (
    .clk(clk), .rst(rst), .rd_req(rd_req), .wr_req(wr_req),
    .dir(dir_w), .busy(busy_o), .wr_go(wr_go_w), .rd_win(rd_win_w)
  );

  bdc_datapath #(.DW(DW)) u_dp (
    .clk(clk), .rst(rst), .dir(dir_w),
    .proc_en(wr_go_w), .periph_en(rd_win_w),
    .proc_wdata(proc_wdata_i), .periph_rdata(periph_rdata_i),
    .proc_bus(proc_bus_o), .periph_bus(periph_bus_o),
    .proc_clash(proc_clash_o), .periph_clash(periph_clash_o)
  );

  assign buf_oe_o = 1'b1;
  assign dir_o    = dir_w;
  assign wr_go_o  = wr_go_w;
  assign rd_win_o = rd_win_w;

  a_r1_oe_held: assert property (@(posedge clk) buf_oe_o);
  a_r7_busy_while_turned: assert property (@(posedge clk) disable iff (rst)
    (dir_o || rd_win_o) |-> busy_o);
endmodule

// File: tb/bus_dir_ctrl_tb.sv
module bus_dir_ctrl_tb;
  localparam int CLK_PER = 10;
  localparam int DW = 8;
  localparam int TURN = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic cs = 0, rd = 0, wr = 0;
  logic [DW-1:0] pw = 8'h00, pr = 8'h00;
  logic oe, dir, busy, wgo, rwin, pc, qc;
  logic [DW-1:0] pbus, qbus;
  int n_run = 0, n_fail = 0, clash_seen = 0, oe_low = 0;

  always #(CLK_PER/2) clk = ~clk;

  bus_dir_ctrl #(.DW(DW), .TURN_CYC(TURN)) u_dut (
    .clk(clk), .rst(rst), .cs_i(cs), .rd_i(rd), .wr_i(wr),
    .proc_wdata_i(pw), .periph_rdata_i(pr),
    .buf_oe_o(oe), .dir_o(dir), .busy_o(busy), .wr_go_o(wgo), .rd_win_o(rwin),
    .proc_bus_o(pbus), .periph_bus_o(qbus),
    .proc_clash_o(pc), .periph_clash_o(qc)
  );

  always @(negedge clk) begin
    if (pc || qc) clash_seen++;
    if (!oe) oe_low++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic t_reset;
    rst = 1; step(2);
    chk("R2 dir", dir, 0); chk("R2 busy", busy, 0); chk("R2 rwin", rwin, 0);
    chk("R1 oe in reset", oe, 1);
    rst = 0; step(1);
    chk("R2 idle after release", busy, 0);
  endtask

  task automatic t_write;
    pw = 8'hA5; cs = 1; wr = 1; #1;
    chk("R8 wr_go idle write", wgo, 1);
    chk("R10 periph side", qbus, 8'hA5);
    step(3);
    chk("R4 dir on write", dir, 0); chk("R4 busy on write", busy, 0);
    cs = 0; wr = 0; #1;
    chk("R8 no wr_go idle", wgo, 0);
    chk("R10 undriven reads 0", qbus, 0);
    cs = 0; rd = 1; step(3);
    chk("R4 rd without cs", dir, 0); chk("R4 rd without cs busy", busy, 0);
    rd = 0;
  endtask

  task automatic t_read;
    pr = 8'h3C; cs = 1; rd = 1; step(1);
    chk("R7 busy turn in", busy, 1); chk("R3 dir held", dir, 0);
    step(TURN - 1);
    chk("R3 dir held last", dir, 0); chk("R9 no window yet", rwin, 0);
    step(1);
    chk("R3 dir flipped", dir, 1); chk("R3 window open", rwin, 1);
    chk("R10 proc side", pbus, 8'h3C);
    rd = 0; cs = 0; step(1);
    chk("R5 window closed", rwin, 0); chk("R5 dir held", dir, 1);
    step(TURN - 1);
    chk("R5 dir held last", dir, 1); chk("R7 busy turn out", busy, 1);
    step(1);
    chk("R5 dir back", dir, 0); chk("R7 idle", busy, 0);
  endtask

  task automatic t_abort;
    cs = 1; rd = 1; step(1);
    rd = 0; cs = 0; step(1);
    chk("R6 dir stays 0", dir, 0); chk("R6 busy", busy, 1);
    step(TURN - 1);
    chk("R6 dir still 0", dir, 0);
    step(1);
    chk("R6 idle", busy, 0); chk("R6 dir end", dir, 0);
  endtask

  task automatic t_write_in_turnout;
    cs = 1; rd = 1; step(TURN + 1);
    chk("R3 read reached", dir, 1);
    rd = 0; wr = 1; pw = 8'h5A; #1;
    chk("R8 held in window", wgo, 0);
    step(1);
    chk("R8 held in turn out", wgo, 0);
    step(TURN - 1);
    chk("R8 held last", wgo, 0);
    step(1);
    chk("R8 released idle", wgo, 1); chk("R10 write through", qbus, 8'h5A);
    cs = 0; wr = 0; step(1);
  endtask

  task automatic t_both;
    cs = 1; rd = 1; wr = 1; #1;
    chk("R8 read wins", wgo, 0);
    step(1);
    chk("R8 read path taken", busy, 1);
    cs = 0; rd = 0; wr = 0; step(TURN + 2);
    chk("R8 back idle", busy, 0);
  endtask

  initial begin
    fork
      begin
        t_reset; t_write; t_read; t_abort; t_write_in_turnout; t_both;
        chk("R11 no clash", clash_seen, 0);
        chk("R1 oe always", oe_low, 0);
      end
      begin
        #(CLK_PER * 5000);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule